// File: doc/BRIEF.md
# Instruction Prefetch Queue with Status

This block sits between a memory bus interface and an instruction decoder and keeps a small first-in, first-out store of instruction bytes. It raises a fetch request while a slot is free and no fetch is outstanding. The bus answers in two steps: it marks the start of a byte cycle and, on a later cycle, returns the byte with an acknowledge. The decoder takes bytes with a pop strobe and says on each pop whether that byte opens a new opcode.

A flush input, driven for example by a taken branch, empties the store. It also makes the block discard the byte of any fetch that was already under way, so old code never reaches the decoder. When the store is empty, a returning byte is offered to the decoder in the same cycle. A two-bit status output, registered and always driven, tells outside logic what the store did in the previous cycle.

Top module: `prefetch_queue`

## Requirements
- R1: The store holds at most DEPTH (default 4) bytes and hands them to the decoder in arrival order; once full, no further fetch is requested.
- R2: `fetch_req` is high exactly when no fetch is outstanding (no `fetch_start` without its `fetch_ack` yet) and fewer than DEPTH bytes are held. It is low while `rst_n` is low.
- R3: With the store empty, an accepted returning byte drives `dec_valid`=1 and `dec_data`=`fetch_data` in its arrival cycle. A pop in that same cycle consumes it and leaves the store empty.
- R4: A pop with `pop_first`=1 that removes a byte gives `qstat`=01 in the next cycle.
- R5: A pop with `pop_first`=0 that removes a byte gives `qstat`=11 in the next cycle.
- R6: A flush gives `qstat`=10 in the next cycle and `dec_valid`=0 after it. A pop in the flush cycle is ignored.
- R7: A cycle with no pop and no flush gives `qstat`=00 next. A pop while `dec_valid`=0 is ignored and also gives 00.
- R8: A fetch that is outstanding when a flush occurs has its byte discarded. This also holds when its acknowledge arrives in the flush cycle itself.
- R9: Reset empties the store, sets `qstat` to 00 and clears any outstanding fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Request for a byte fetch |
| fetch_start | input | 1 | Bus begins the requested byte cycle |
| fetch_ack | input | 1 | Fetched byte is on `fetch_data` |
| fetch_data | input | W | Fetched byte |
| pop | input | 1 | Decoder takes the head byte |
| pop_first | input | 1 | The popped byte is the first byte of an opcode |
| dec_valid | output | 1 | A byte is available to the decoder |
| dec_data | output | W | Head byte, or the arriving byte when the store is empty |
| flush | input | 1 | Discard all held and in-flight bytes |
| qstat | output | 2 | Status of the previous cycle's operation |

## Verification
The bench builds the block with its defaults, DEPTH=4 and W=8. With that depth, four fetches reach the full state, so request withdrawal and wrap-around of the read and write pointers both come into play over a few fill and drain rounds. Flush timing is tested at each point of the fetch handshake: before the acknowledge and in the same cycle as the acknowledge. Status codes are checked one cycle after each operation.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         fetch_req,
  input  logic         fetch_start,
  input  logic         fetch_ack,
  input  logic [W-1:0] fetch_data,
  input  logic         pop,
  input  logic         pop_first,
  output logic         dec_valid,
  output logic [W-1:0] dec_data,
  input  logic         flush,
  output logic [1:0]   qstat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] ST_IDLE = 2'b00, ST_FIRST = 2'b01, ST_FLUSH = 2'b10, ST_NEXT = 2'b11;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          inflight, drop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire empty   = (count == '0);
  wire ack_ok  = fetch_ack && inflight && !drop && !flush;
  wire pop_eff = pop && dec_valid && !flush;
  wire deq     = pop_eff && !empty;
  wire enq     = ack_ok && !(empty && pop_eff);

  assign dec_valid = !empty || ack_ok;
  assign dec_data  = empty ? fetch_data : mem[rd_ptr];
  assign fetch_req = rst_n && !inflight && (count < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (enq) mem[wr_ptr] <= fetch_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      inflight <= 1'b0;
      drop     <= 1'b0;
      qstat    <= ST_IDLE;
    end else begin
      if (fetch_ack) inflight <= 1'b0;
      else if (fetch_start && fetch_req) inflight <= 1'b1;

      if (fetch_ack) drop <= 1'b0;
      else if (flush && inflight) drop <= 1'b1;

      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        count  <= '0;
      end else begin
        if (enq) wr_ptr <= bump(wr_ptr);
        if (deq) rd_ptr <= bump(rd_ptr);
        count <= count + CW'(enq) - CW'(deq);
      end

      if (flush)        qstat <= ST_FLUSH;
      else if (pop_eff) qstat <= pop_first ? ST_FIRST : ST_NEXT;
      else              qstat <= ST_IDLE;
    end
  end
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int DEPTH = 4,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fetch_req,
  input logic         fetch_ack,
  input logic [W-1:0] fetch_data,
  input logic         pop,
  input logic         flush,
  input logic         dec_valid,
  input logic [W-1:0] dec_data,
  input logic [1:0]   qstat,
  input logic [CW-1:0] count,
  input logic         inflight,
  input logic         drop
);
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_req_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (count < CW'(DEPTH)) && !inflight);
  a_r2_req_low_in_reset: assert property (@(posedge clk) !rst_n |-> !fetch_req);
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && fetch_ack && inflight && !drop && !flush) |-> dec_valid && dec_data == fetch_data);
  a_r6_flush_status: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> qstat == 2'b10 && count == '0);
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !dec_valid && !flush) |=> qstat == 2'b00);
  a_r8_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && fetch_ack && count == '0) |-> !dec_valid);
endmodule

bind prefetch_queue prefetch_queue_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .fetch_data(fetch_data), .pop(pop), .flush(flush), .dec_valid(dec_valid),
  .dec_data(dec_data), .qstat(qstat), .count(count), .inflight(inflight), .drop(drop)
);

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  logic clk = 0, rst_n = 0;
  logic fetch_req, fetch_start = 0, fetch_ack = 0, pop = 0, pop_first = 0, flush = 0;
  logic [7:0] fetch_data = 0, dec_data;
  logic dec_valid;
  logic [1:0] qstat;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  prefetch_queue u_dut (.clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_start(fetch_start),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .pop(pop), .pop_first(pop_first),
    .dec_valid(dec_valid), .dec_data(dec_data), .flush(flush), .qstat(qstat));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start_fetch();
    chk("R2 req before start", fetch_req, 1);
    fetch_start = 1; cyc(); fetch_start = 0;
  endtask

  task automatic do_fetch(input logic [7:0] d);
    start_fetch();
    fetch_ack = 1; fetch_data = d; cyc(); fetch_ack = 0;
  endtask

  task automatic do_pop(input logic first, input logic [7:0] exp, input string req);
    chk({req, " dec_valid"}, dec_valid, 1);
    chk({req, " dec_data"}, dec_data, exp);
    pop = 1; pop_first = first; cyc(); pop = 0; pop_first = 0;
    chk({req, " qstat"}, qstat, first ? 1 : 3);
  endtask

  task automatic t_reset();
    chk("R9 qstat in reset", qstat, 0);
    chk("R2 req low in reset", fetch_req, 0);
    chk("R9 dec_valid in reset", dec_valid, 0);
    rst_n = 1; cyc();
    chk("R2 req after reset", fetch_req, 1);
    chk("R7 idle status", qstat, 0);
  endtask

  task automatic t_fill_drain(input logic [7:0] base);
    for (int i = 0; i < 4; i++) do_fetch(base + 8'(i));
    chk("R1 req low when full", fetch_req, 0);
    do_pop(1, base, "R4 first");
    chk("R2 req after slot frees", fetch_req, 1);
    do_pop(0, base + 1, "R5 next");
    do_pop(0, base + 2, "R5 next");
    do_pop(1, base + 3, "R1 order");
    chk("R1 empty after drain", dec_valid, 0);
  endtask

  task automatic t_bypass();
    start_fetch();
    fetch_ack = 1; fetch_data = 8'h9C;
    #1;
    chk("R3 bypass valid", dec_valid, 1);
    chk("R3 bypass data", dec_data, 8'h9C);
    pop = 1; pop_first = 1; cyc(); pop = 0; pop_first = 0; fetch_ack = 0;
    chk("R3 bypass status", qstat, 1);
    chk("R3 store stays empty", dec_valid, 0);
  endtask

  task automatic t_flush_pop();
    do_fetch(8'h11); do_fetch(8'h22);
    flush = 1; pop = 1; pop_first = 1; cyc(); flush = 0; pop = 0; pop_first = 0;
    chk("R6 flush status", qstat, 2);
    chk("R6 empty after flush", dec_valid, 0);
    cyc();
    chk("R7 idle after flush", qstat, 0);
  endtask

  task automatic t_stale();
    start_fetch();
    flush = 1; cyc(); flush = 0;
    chk("R8 req low while stale fetch pending", fetch_req, 0);
    fetch_ack = 1; fetch_data = 8'hEE;
    #1 chk("R8 stale byte not offered", dec_valid, 0);
    cyc(); fetch_ack = 0;
    chk("R8 stale byte not stored", dec_valid, 0);
    do_fetch(8'h55);
    do_pop(1, 8'h55, "R8 fresh byte");
  endtask

  task automatic t_flush_ack();
    start_fetch();
    fetch_ack = 1; fetch_data = 8'hDD; flush = 1;
    cyc(); fetch_ack = 0; flush = 0;
    chk("R8 ack in flush cycle dropped", dec_valid, 0);
    chk("R6 status", qstat, 2);
  endtask

  task automatic t_empty_pop();
    pop = 1; pop_first = 1; cyc(); pop = 0; pop_first = 0;
    chk("R7 empty pop status", qstat, 0);
    chk("R7 empty pop valid", dec_valid, 0);
    do_fetch(8'h77);
    do_pop(0, 8'h77, "R7 store intact");
  endtask

  task automatic t_reset_mid();
    do_fetch(8'h31); start_fetch();
    rst_n = 0; #1;
    chk("R2 req low in reset", fetch_req, 0);
    chk("R9 store cleared", dec_valid, 0);
    cyc(); rst_n = 1; cyc();
    chk("R9 outstanding fetch cleared", fetch_req, 1);
    chk("R9 qstat", qstat, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_fill_drain(8'hA0);
    t_fill_drain(8'hB4);
    t_bypass();
    t_flush_pop();
    t_stale();
    t_flush_ack();
    t_empty_pop();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule